// File: doc/BRIEF.md
# Tick-Sampled Serial Receiver with Handshaked Receive Ring

This block turns an asynchronous 8N1 serial line into bytes held in a small circular buffer for a host. A periodic sample tick paces the receiver. While idle, a low line level seen on a tick marks a start bit. The receiver then waits one and a half bit periods and takes the first data sample. After that it samples once per bit period, and a final sample covers the stop position. The bit period comes from an input, or from a fixed pair of constants when the fixed-rate input is high.

Each finished byte goes into a ring with a depth set by a parameter (16 by default). The ring keeps one slot free. A byte that would leave the ring completely full is thrown away. When that happens, the ready handshake outputs are dropped and a sticky overrun flag is raised. The host takes bytes out with a single-cycle pop strobe. Each pop re-raises the handshake. A pop on an empty ring returns zero.

Top module: `serial_rx_ring`

## Requirements
- R1: After reset, `fill_level` is 0, `pop_data` is 0x00, `cts` and `dsr` are 1, and `overrun` is 0.
- R2: The line passes through two synchronizing flops. When idle, a synchronized low seen on a `tick` starts a frame. The first sample comes `bit_period + floor(bit_period/2)` ticks after that detection tick. Each later sample comes `bit_period` ticks after the one before. There are 9 samples in all: 8 data bits and one stop position. The stop level is not checked and is not stored. `bit_period` must be at least 2.
- R3: Data is assembled LSB first, so the first data bit on the line becomes bit 0 of the stored byte.
- R4: When `fixed_rate` is 1, the receiver uses a bit period of 24 ticks and a start delay of 36 ticks, and ignores `bit_period`.
- R5: A byte completed while `fill_level` is below DEPTH-1 is stored, and `fill_level` goes up by one.
- R6: A pop on a non-empty ring puts the oldest byte on `pop_data` one clock later and lowers `fill_level` by one. A pop on an empty ring loads `pop_data` with 0x00 and leaves `fill_level` unchanged.
- R7: A byte completed while `fill_level` equals DEPTH-1 is discarded. `fill_level` stays at DEPTH-1, and `cts` and `dsr` go to 0.
- R8: A pop, or an accepted store, drives `cts` and `dsr` back to 1. If a discard happens in the same cycle, the discard wins.
- R9: `overrun` goes to 1 on a discard and stays at 1 until `ovr_clr` is pulsed. If a discard and a clear fall in the same cycle, the flag is set.
- R10: Bytes leave in arrival order, including when the read and write positions wrap past the end of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample tick, one clock wide |
| fixed_rate | input | 1 | 1 selects the fixed 24/36 tick timing |
| bit_period | input | PW | Bit period in ticks when `fixed_rate` is 0 |
| rx_line | input | 1 | Serial input, idle high |
| pop | input | 1 | Host read strobe |
| ovr_clr | input | 1 | Clears the overrun flag |
| pop_data | output | 8 | Byte returned by the last pop |
| fill_level | output | $clog2(DEPTH)+1 | Number of bytes stored |
| cts | output | 1 | Ready handshake |
| dsr | output | 1 | Ready handshake, copy of `cts` |
| overrun | output | 1 | Sticky flag for a discarded byte |

## Verification
The hardest state to reach is the discard boundary. Getting there takes a ring holding exactly DEPTH-1 bytes, with the read position already moved off zero, and then one more complete frame. To set this up, the stimulus first receives and drains four bytes. It then streams fifteen frames back to back at a short bit period, followed by a sixteenth. This puts the overflow decision on wrapped pointers. After that, single pops and a clear pulse show that the handshake recovers on the first read and that the overrun flag waits for its clear.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_BITS     = 8;
  localparam int FRAME_SAMPLES = DATA_BITS + 1;
  localparam int FIXED_PERIOD  = 24;
  localparam int FIXED_START   = 36;

  typedef enum logic {RX_IDLE = 1'b0, RX_BUSY = 1'b1} rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/srx_framer.sv
module srx_framer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fixed_rate,
  input  logic [PW-1:0] bit_period,
  input  logic          rx_s,
  output logic          byte_valid,
  output logic [7:0]    byte_data
);
  import srx_pkg::*;

  localparam int DW = PW + 1;
  localparam int LW = $clog2(FRAME_SAMPLES + 1);

  rx_state_e st_q, st_n;
  logic [LW-1:0] left_q, left_n;
  logic [DW-1:0] dly_q, dly_n;
  logic [DATA_BITS-1:0] sh_q, sh_n;
  logic done_q, done_n;
  logic [DW-1:0] per_w, start_w;

  always_comb begin
    per_w   = fixed_rate ? DW'(FIXED_PERIOD) : {1'b0, bit_period};
    start_w = fixed_rate ? DW'(FIXED_START)
                         : ({1'b0, bit_period} + DW'(bit_period >> 1));
  end

  always_comb begin
    st_n   = st_q;
    left_n = left_q;
    dly_n  = dly_q;
    sh_n   = sh_q;
    done_n = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rx_s) begin
            st_n   = RX_BUSY;
            left_n = LW'(FRAME_SAMPLES);
            dly_n  = start_w;
          end
        end
        RX_BUSY: begin
          if (dly_q <= DW'(1)) begin
            if (left_q == LW'(1)) begin
              done_n = 1'b1;
              st_n   = RX_IDLE;
            end else begin
              sh_n   = {rx_s, sh_q[DATA_BITS-1:1]};
              left_n = left_q - LW'(1);
            end
            dly_n = per_w;
          end else begin
            dly_n = dly_q - DW'(1);
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      left_q <= '0;
      dly_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      left_q <= left_n;
      dly_q  <= dly_n;
      sh_q   <= sh_n;
      done_q <= done_n;
    end
  end

  assign byte_valid = done_q;
  assign byte_data  = sh_q;

  assert_start_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && tick && !rx_s) |=> (st_q == RX_BUSY))
    else $error("start not taken");

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid)
    else $error("byte_valid wider than one cycle");
endmodule

// File: rtl/srx_ring.sv
module srx_ring #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [7:0]                 push_data,
  input  logic                       pop,
  input  logic                       ovr_clr,
  output logic [7:0]                 pop_data,
  output logic [$clog2(DEPTH):0]     fill,
  output logic                       hs_ready,
  output logic                       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [7:0]    dout_q, dout_n;
  logic          hs_q, hs_n, ovr_q, ovr_n;
  logic          drop_w, store_w, take_w;

  always_comb begin
    drop_w  = push_valid && (cnt_q == CW'(DEPTH - 1));
    store_w = push_valid && !drop_w;
    take_w  = pop && (cnt_q != '0);

    wr_n = wr_q;
    if (store_w) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    rd_n = rd_q;
    if (take_w) rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);

    cnt_n = cnt_q + CW'(store_w) - CW'(take_w);

    dout_n = dout_q;
    if (pop) dout_n = take_w ? mem[rd_q] : 8'h00;

    hs_n = hs_q;
    if (pop || store_w) hs_n = 1'b1;
    if (drop_w)         hs_n = 1'b0;

    ovr_n = ovr_q;
    if (ovr_clr) ovr_n = 1'b0;
    if (drop_w)  ovr_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (store_w) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      dout_q <= 8'h00;
      hs_q   <= 1'b1;
      ovr_q  <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
      dout_q <= dout_n;
      hs_q   <= hs_n;
      ovr_q  <= ovr_n;
    end
  end

  assign pop_data = dout_q;
  assign fill     = cnt_q;
  assign hs_ready = hs_q;
  assign overrun  = ovr_q;

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH - 1))
    else $error("ring holds too many bytes");

  assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fill == CW'(DEPTH - 1)) |=> (overrun && !hs_ready))
    else $error("discard did not flag");

  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fill == '0) |=> (pop_data == 8'h00 && $stable(fill)))
    else $error("empty pop misbehaved");

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !pop) |=> $stable(fill))
    else $error("fill moved without traffic");

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun)
    else $error("overrun lost");
endmodule

// File: rtl/serial_rx_ring.sv
module serial_rx_ring #(
  parameter int DEPTH = 16,
  parameter int PW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   fixed_rate,
  input  logic [PW-1:0]          bit_period,
  input  logic                   rx_line,
  input  logic                   pop,
  input  logic                   ovr_clr,
  output logic [7:0]             pop_data,
  output logic [$clog2(DEPTH):0] fill_level,
  output logic                   cts,
  output logic                   dsr,
  output logic                   overrun
);
  logic       rx_s;
  logic       bv;
  logic [7:0] bd;
  logic       ready;

  srx_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (rx_s)
  );

  srx_framer #(.PW(PW)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .fixed_rate(fixed_rate),
    .bit_period(bit_period),
    .rx_s      (rx_s),
    .byte_valid(bv),
    .byte_data (bd)
  );

  srx_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(bv),
    .push_data (bd),
    .pop       (pop),
    .ovr_clr   (ovr_clr),
    .pop_data  (pop_data),
    .fill      (fill_level),
    .hs_ready  (ready),
    .overrun   (overrun)
  );

  assign cts = ready;
  assign dsr = ready;

  assert_hs_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cts == dsr)
    else $error("handshake pair split");
endmodule

// File: tb/serial_rx_ring_test.sv
module serial_rx_ring_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic fixed_rate = 1'b0;
  logic [7:0] bit_period = 8'd8;
  logic rx_line = 1'b1;
  logic pop = 1'b0;
  logic ovr_clr = 1'b0;
  logic [7:0] pop_data;
  logic [4:0] fill_level;
  logic cts, dsr, overrun;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_gap = 1;
  int tick_cnt = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int m_s1, m_s2, m_busy, m_left, m_dly, m_sh, m_pv, m_pb;
  int m_data, m_hs, m_ovr;
  int q[$];

  serial_rx_ring #(.DEPTH(DEPTH), .PW(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fixed_rate(fixed_rate),
    .bit_period(bit_period), .rx_line(rx_line), .pop(pop), .ovr_clr(ovr_clr),
    .pop_data(pop_data), .fill_level(fill_level), .cts(cts), .dsr(dsr),
    .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // tick generator
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1 >= tick_gap) ? 0 : tick_cnt + 1;
    tick = (tick_cnt == 0);
  end

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_busy = 0; m_left = 0; m_dly = 0; m_sh = 0;
      m_pv = 0; m_pb = 0; m_data = 0; m_hs = 1; m_ovr = 0; q.delete();
    end else begin
      int old_sz, per, strt, samp;
      bit drop;
      old_sz = q.size();
      drop = m_pv && (old_sz + 1 == DEPTH);
      if (pop) begin
        if (old_sz != 0) m_data = q.pop_front();
        else m_data = 0;
      end
      if (m_pv && !drop) q.push_back(m_pb);
      if (pop || (m_pv && !drop)) m_hs = 1;
      if (drop) m_hs = 0;
      if (ovr_clr) m_ovr = 0;
      if (drop) m_ovr = 1;
      m_pv = 0;
      samp = m_s2;
      per  = fixed_rate ? 24 : int'(bit_period);
      strt = fixed_rate ? 36 : int'(bit_period) + int'(bit_period) / 2;
      if (tick) begin
        if (!m_busy) begin
          if (samp == 0) begin m_busy = 1; m_left = 9; m_dly = strt; end
        end else if (m_dly <= 1) begin
          if (m_left == 1) begin m_pv = 1; m_pb = m_sh; m_busy = 0; end
          else begin m_sh = (m_sh >> 1) | (samp << 7); m_left--; end
          m_dly = per;
        end else m_dly--;
      end
      m_s2 = m_s1;
      m_s1 = rx_line;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 fill_level vs model", fill_level, q.size());
      chk("R6 pop_data vs model", pop_data, m_data);
      chk("R8 cts vs model", cts, m_hs);
      chk("R8 dsr vs model", dsr, m_hs);
      chk("R9 overrun vs model", overrun, m_ovr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic send_byte(input logic [7:0] b, input int bit_clk);
    @(negedge clk) rx_line = 1'b0;
    repeat (bit_clk - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rx_line = b[i];
      repeat (bit_clk - 1) @(negedge clk);
    end
    @(negedge clk) rx_line = 1'b1;
    repeat (3 * bit_clk) @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is still held
    chk("R1 fill_level", fill_level, 0);
    chk("R1 pop_data", pop_data, 0);
    chk("R1 cts", cts, 1);
    chk("R1 dsr", dsr, 1);
    chk("R1 overrun", overrun, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: LSB-first assembly, programmable period 8, tick every clock
    tick_gap = 1; bit_period = 8'd8;
    send_byte(8'hA5, 8);
    chk("R5 one byte stored", fill_level, 1);
    do_pop();
    chk("R3 lsb first 0xA5", pop_data, 8'hA5);

    // R2: odd period with sparse ticks
    tick_gap = 3; bit_period = 8'd5;
    send_byte(8'h3C, 15);
    send_byte(8'h81, 15);
    chk("R2 two bytes stored", fill_level, 2);
    do_pop();
    chk("R2 first byte 0x3C", pop_data, 8'h3C);
    do_pop();
    chk("R2 second byte 0x81", pop_data, 8'h81);

    // R4: fixed timing ignores bit_period
    tick_gap = 1; fixed_rate = 1'b1; bit_period = 8'd5;
    send_byte(8'h5A, 24);
    do_pop();
    chk("R4 fixed rate byte 0x5A", pop_data, 8'h5A);
    fixed_rate = 1'b0; bit_period = 8'd8;

    // R6: empty pop returns zero
    do_pop();
    chk("R6 empty pop data", pop_data, 8'h00);
    chk("R6 empty pop fill", fill_level, 0);

    // R7/R10: fill to DEPTH-1 across the wrap, then one extra
    for (int i = 0; i < DEPTH - 1; i++) send_byte(8'(8'h10 + i), 8);
    chk("R5 ring at limit", fill_level, DEPTH - 1);
    chk("R8 cts still ready", cts, 1);
    send_byte(8'hEE, 8);
    chk("R7 fill unchanged on discard", fill_level, DEPTH - 1);
    chk("R7 cts dropped", cts, 0);
    chk("R7 dsr dropped", dsr, 0);
    chk("R9 overrun set", overrun, 1);
    do_pop();
    chk("R10 oldest after wrap", pop_data, 8'h10);
    chk("R8 cts back on read", cts, 1);
    chk("R9 overrun sticky", overrun, 1);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk("R9 overrun cleared", overrun, 0);
    for (int i = 1; i < DEPTH - 1; i++) begin
      do_pop();
      chk("R10 order across wrap", pop_data, 8'h10 + i);
    end
    chk("R6 drained", fill_level, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule